// File: doc/BRIEF.md
# Pixel Time-Slot Hit Buffer

This block is the digital back end of one detector pixel. It counts discriminator pulses during the current time slot. At the next rising edge of the slot clock it hands that count to the readout side, so acquisition never stops. Two identical counters trade roles. One accumulates hits for the running slot while the other holds the closed slot's total for the group arbiter. The swap happens only when the slot that just ended saw activity, which keeps switching low at the sparse occupancy these detectors run at.

The arbiter sees a request line and a count bus. Once it has taken the count, it pulses an acknowledge. That drops the request and zeroes the readout counter. Two per-pixel configuration bits control the pixel. One removes the pixel from service entirely. The other forces the pixel to report every slot even with zero hits. A global imaging-mode input forces reporting for all pixels at once, so the whole array can be read as a sequence of count frames.

Top module: `tsb_pixel_top`

## Requirements
- R1: After reset, `hit_req` is 0 and `rd_count` is 0.
- R2: Each low-to-high transition of `disc_in`, after a two-stage synchronizer, adds exactly one to the acquiring counter. A level held high adds nothing further.
- R3: On a `slot_clk` rising edge, the counters swap when the closing slot registered a hit. One `clk` cycle later, `hit_req` is 1 and `rd_count` shows that slot's count.
- R4: On a `slot_clk` rising edge with no hit in the closing slot, and neither force input active, no swap occurs. `hit_req` and `rd_count` keep their values.
- R5: A `disc_in` pulse that stays high across a slot edge is counted once, in the slot where it rose. It adds nothing to the following slot.
- R6: A rising transition that leaves the synchronizer in the same `clk` cycle as a slot edge belongs to the new slot. It does not appear in the count being handed over.
- R7: A 1 on `rd_ack` clears `hit_req` and `rd_count` to 0 at the next `clk` edge. If a swap happens in that same cycle, the swap wins: `hit_req` stays 1 with the new count.
- R8: Counters saturate at 31 (all ones in 5 bits) and do not wrap.
- R9: While `cfg_kill` is 1, no hits are counted and no swap or new request occurs. This holds even when `cfg_set` or `img_mode` is 1.
- R10: With `cfg_set` or `img_mode` at 1 and `cfg_kill` at 0, every slot edge swaps and asserts `hit_req`. `rd_count` then carries the real hit count, which may be 0.
- R11: A swap arriving before the previous count was acknowledged replaces that count with the new slot's count. `hit_req` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disc_in | input | 1 | Discriminator output, asynchronous |
| slot_clk | input | 1 | Time-slot clock, synchronous to `clk`, rising edge closes a slot |
| rd_ack | input | 1 | Readout acknowledge from the group arbiter |
| cfg_set | input | 1 | Force the pixel to report every slot |
| cfg_kill | input | 1 | Remove the pixel from hit reception (wins over set) |
| img_mode | input | 1 | Imaging mode, behaves as set for this pixel |
| hit_req | output | 1 | Readout request to the arbiter |
| rd_count | output | 5 | Hit count of the slot under readout |

## Verification
The bench targets slot-boundary attribution. It holds a pulse high across a slot edge, where a design that re-armed on level would add a phantom count to the next slot. It also lands a synchronized rising edge in the exact cycle of the slot edge, where a wrong design leaks that hit into the handed-over count. Other cases are an empty slot, where a careless design swaps anyway and presents a stale or zeroed count as a fresh request, and an acknowledge coinciding with a swap, which a wrong priority would turn into a lost request. Saturation past 31, kill overriding set and imaging mode, and overwrite of unacknowledged data are driven by random slots whose expected request and count come from bench functions.

// File: rtl/tsb_pkg.sv
// Shared constants for the pixel time-slot hit buffer.
// Assumes: all users take widths from here unless overridden.
package tsb_pkg;
    parameter int unsigned TSB_CNT_W       = 5;
    parameter int unsigned TSB_SYNC_STAGES = 2;
endpackage

// File: rtl/tsb_disc_sync.sv
// Brings the asynchronous discriminator into the clk domain and emits a
// one-cycle pulse on each synchronized rising transition.
// Assumes: STAGES >= 2; input pulses are wider than one clk period.
module tsb_disc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;
    logic              level;

    assign level = chain_q[STAGES-1];

    // synchronizer chain plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
            last_q  <= level;
        end
    end

    assign rise = level & ~last_q;

    // R2
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tsb_slot_ctrl.sv
// Tracks whether the running slot saw activity, decides at each slot edge
// whether counters swap, and owns the readout request.
// Assumes: slot_clk is synchronous to clk; hit_ev is already gated by kill.
module tsb_slot_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_clk,
    input  logic hit_ev,
    input  logic force_req,
    input  logic kill,
    input  logic rd_ack,
    output logic swap,
    output logic clr_rd,
    output logic acq_sel,
    output logic req
);
    logic slot_q;
    logic pend_q;
    logic slot_rise;

    assign slot_rise = slot_clk & ~slot_q;
    assign swap      = slot_rise & ~kill & (pend_q | force_req);
    assign clr_rd    = rd_ack & ~swap;

    // remember previous slot clock level
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= 1'b0;
        else        slot_q <= slot_clk;
    end

    // waiting stage: a hit seen in the running slot
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (kill)      pend_q <= 1'b0;
        else if (slot_rise) pend_q <= hit_ev;
        else if (hit_ev)    pend_q <= 1'b1;
    end

    // role select: flips only on a swap
    always_ff @(posedge clk) begin
        if (!rst_n)    acq_sel <= 1'b0;
        else if (swap) acq_sel <= ~acq_sel;
    end

    // service stage: request raised by swap, dropped by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)      req <= 1'b0;
        else if (swap)   req <= 1'b1;
        else if (rd_ack) req <= 1'b0;
    end

    // R4
    no_idle_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_rise && !pend_q && !force_req) |=> $stable(acq_sel));

    // R7
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !swap) |=> !req);

    // R3
    swap_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> req);
endmodule

// File: rtl/tsb_count_bank.sv
// Two saturating hit counters whose acquire and readout roles alternate.
// Assumes: swap and clr_rd are never both 1 in a cycle.
module tsb_count_bank #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acq_sel,
    input  logic             swap,
    input  logic             hit_ev,
    input  logic             clr_rd,
    output logic [CNT_W-1:0] rd_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_w [2];

    for (genvar i = 0; i < 2; i++) begin : g_ctr
        localparam logic ME = 1'(i);
        logic [CNT_W-1:0] val_q;

        // counter update: restart on becoming acquirer, count, or clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (swap) begin
                if (acq_sel != ME) val_q <= hit_ev ? CNT_ONE : '0;
            end else if (acq_sel == ME) begin
                if (hit_ev && val_q != CNT_MAX) val_q <= val_q + CNT_ONE;
            end else if (clr_rd) begin
                val_q <= '0;
            end
        end

        assign cnt_w[i] = val_q;

        // R8
        sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (val_q == CNT_MAX && !swap && acq_sel == ME) |=> val_q == CNT_MAX);
    end

    assign rd_count = acq_sel ? cnt_w[0] : cnt_w[1];
endmodule

// File: rtl/tsb_pixel_top.sv
// Per-pixel time-slot hit buffer: synchronizes the discriminator, gates it
// with the kill/set configuration, and feeds the slot control and counters.
// Assumes: slot_clk and rd_ack are synchronous to clk.
module tsb_pixel_top #(
    parameter int unsigned CNT_W       = tsb_pkg::TSB_CNT_W,
    parameter int unsigned SYNC_STAGES = tsb_pkg::TSB_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disc_in,
    input  logic             slot_clk,
    input  logic             rd_ack,
    input  logic             cfg_set,
    input  logic             cfg_kill,
    input  logic             img_mode,
    output logic             hit_req,
    output logic [CNT_W-1:0] rd_count
);
    logic disc_rise;
    logic hit_ev;
    logic force_req;
    logic swap;
    logic clr_rd;
    logic acq_sel;

    tsb_disc_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (disc_in),
        .rise (disc_rise)
    );

    assign hit_ev    = disc_rise & ~cfg_kill;
    assign force_req = (cfg_set | img_mode) & ~cfg_kill;

    tsb_slot_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_clk (slot_clk),
        .hit_ev   (hit_ev),
        .force_req(force_req),
        .kill     (cfg_kill),
        .rd_ack   (rd_ack),
        .swap     (swap),
        .clr_rd   (clr_rd),
        .acq_sel  (acq_sel),
        .req      (hit_req)
    );

    tsb_count_bank #(.CNT_W(CNT_W)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .acq_sel (acq_sel),
        .swap    (swap),
        .hit_ev  (hit_ev),
        .clr_rd  (clr_rd),
        .rd_count(rd_count)
    );

    // R9
    kill_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_kill && !hit_req) |=> !hit_req);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap && !rd_ack) |=> $stable(rd_count));
endmodule

// File: tb/tsb_pixel_top_tb_top.sv
module tsb_pixel_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disc_in = 1'b0;
    logic       slot_clk = 1'b0;
    logic       rd_ack = 1'b0;
    logic       cfg_set = 1'b0;
    logic       cfg_kill = 1'b0;
    logic       img_mode = 1'b0;
    logic       hit_req;
    logic [4:0] rd_count;

    int tests = 0;
    int fails = 0;
    logic       exp_req = 1'b0;
    logic [4:0] exp_cnt = '0;

    always #4 clk = ~clk;

    tsb_pixel_top dut_i (
        .clk(clk), .rst_n(rst_n), .disc_in(disc_in), .slot_clk(slot_clk),
        .rd_ack(rd_ack), .cfg_set(cfg_set), .cfg_kill(cfg_kill),
        .img_mode(img_mode), .hit_req(hit_req), .rd_count(rd_count)
    );

    function automatic logic exp_swap(logic k, logic s, logic im, int n);
        return !k && (n > 0 || s || im);
    endfunction

    function automatic logic [4:0] exp_count(int n);
        return (n > 31) ? 5'd31 : 5'(n);
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, logic er, logic [4:0] ec);
        tests++;
        if (hit_req !== er || rd_count !== ec) begin
            fails++;
            $display("FAIL %s: req=%0b cnt=%0d expected req=%0b cnt=%0d",
                     tag, hit_req, rd_count, er, ec);
        end
    endtask

    task automatic pulses(int n);
        for (int k = 0; k < n; k++) begin
            disc_in = 1'b1; tick(2);
            disc_in = 1'b0; tick(3);
        end
    endtask

    task automatic slot_edge();
        slot_clk = 1'b1; tick(1);
        slot_clk = 1'b0;
    endtask

    task automatic do_ack();
        rd_ack = 1'b1; tick(1);
        rd_ack = 1'b0;
        exp_req = 1'b0; exp_cnt = '0;
    endtask

    initial begin
        #(8 * 200000);
        fails++; tests++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R1 reset", 1'b0, 5'd0);

        // R2 R3: basic counting and swap
        pulses(3); tick(4); slot_edge();
        check("R3 swap after 3 hits (R2)", 1'b1, 5'd3);
        do_ack(); check("R7 ack clears", 1'b0, 5'd0);

        // R5: pulse spanning the slot edge counted once
        pulses(2); disc_in = 1'b1; tick(5); slot_edge();
        check("R5 span counted in first slot", 1'b1, 5'd3);
        do_ack(); tick(4); disc_in = 1'b0; tick(4); slot_edge();
        check("R5 no second count / R4 no swap", 1'b0, 5'd0);

        // R6: rise leaves synchronizer in the slot-edge cycle
        pulses(2); tick(2);
        disc_in = 1'b1; tick(2);
        slot_edge();
        check("R6 boundary hit excluded", 1'b1, 5'd2);
        disc_in = 1'b0; tick(3); do_ack(); tick(2); slot_edge();
        check("R6 boundary hit in new slot", 1'b1, 5'd1);
        do_ack();

        // R7: ack coinciding with swap, swap wins
        pulses(4); tick(2);
        slot_clk = 1'b1; rd_ack = 1'b1; tick(1);
        slot_clk = 1'b0; rd_ack = 1'b0;
        check("R7 swap beats ack", 1'b1, 5'd4);
        do_ack();

        // R8: saturation
        pulses(35); tick(4); slot_edge();
        check("R8 saturate at 31", 1'b1, 5'd31);
        do_ack();

        // R9: kill wins over set
        cfg_kill = 1'b1; cfg_set = 1'b1; pulses(3); tick(2); slot_edge();
        check("R9 kill blocks", 1'b0, 5'd0);
        cfg_kill = 1'b0; tick(2); slot_edge();
        check("R10 set reports zero", 1'b1, 5'd0);
        cfg_set = 1'b0;

        // R11: unacknowledged count replaced
        pulses(5); tick(3); slot_edge();
        check("R11 overwrite", 1'b1, 5'd5);
        exp_req = 1'b1; exp_cnt = 5'd5;

        // random slots
        for (int s = 0; s < 60; s++) begin
            logic k, st, im;
            int n;
            k  = ($urandom % 6) == 0;
            st = ($urandom % 5) == 0;
            im = ($urandom % 8) == 0;
            n  = (($urandom % 10) == 0) ? 30 + int'($urandom % 8) : int'($urandom % 6);
            cfg_kill = k; cfg_set = st; img_mode = im;
            tick(1);
            pulses(n); tick(3);
            slot_edge();
            if (exp_swap(k, st, im, n)) begin
                exp_req = 1'b1; exp_cnt = exp_count(n);
            end
            check("R2/R3/R4/R8/R9/R10/R11 random slot", exp_req, exp_cnt);
            cfg_kill = 1'b0; cfg_set = 1'b0; img_mode = 1'b0;
            if (($urandom % 2) == 0) begin
                do_ack();
                check("R7 random ack", exp_req, exp_cnt);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule